// File: doc/BRIEF.md
# Recovery Interface Bypass Register Controller

This block is the control and status register file for a firmware-recovery interface. The interface can run in two modes. After reset it uses a serial bus, and a separate protocol engine drives the recovery traffic. Software can instead select a direct bus-access bypass mode at run time. In bypass mode, a processor on the chip pushes the recovery image over the system bus and takes over the register updates that bus commands would otherwise make.

A simple single-cycle register port gives access to the following registers:
- a device-status word,
- a recovery-status word,
- a recovery-control word,
- an interface-configuration word,
- a read-only FIFO-status word,
- a write-one-to-clear proxy word.

The proxy lets bypass software clear recovery-control bits; clearing the activation field activates the new image. A self-clearing payload-done bit in the configuration word sends a one-cycle payload-available pulse to the recovery consumer. The recovery-status word steps through its encodings as the recovery sequence progresses.

Top module: `rcv_csr_ctrl`

## Requirements
- R1: After reset, `bypass_o`, `payload_avail_o`, `activate_o` and `rd_valid` are 0, and the recovery-control and configuration words read 0. Recovery status reads 0x0.
- R2: Configuration word (address 3) bit 0 is the mode bit: 0 selects serial-bus mode and 1 selects bypass mode. It is read/write, and `bypass_o` follows it from the cycle after the write.
- R3: Device status (address 0, bits [7:0]) reads 0x03 while `dev_rec_ready` is high and 0x01 otherwise.
- R4: Recovery status (address 1, bits [3:0]) only moves forward, with these steps and codes:
  - idle 0x0 moves to awaiting image 0x1 when `dev_rec_ready` is high;
  - 0x1 moves to booting image 0x2 on a payload-available pulse;
  - 0x2 moves to recovery successful 0x3 only when `image_active` is high after an activation made while in 0x2.
- R5: Writing 1 to configuration bit 1 while in bypass mode makes `payload_avail_o` high for exactly the next cycle. The bit then reads 0. In serial-bus mode the bit is ignored.
- R6: Recovery control (address 2) holds bits [11:0] as read/write. Bits [11:8] are the activation field, and the upper bits read 0.
- R7: In bypass mode, a write to the proxy (address 4) clears exactly those recovery-control bits that are set in both the write data and the register. Writing 0xF00 clears the activation field. The proxy itself reads 0.
- R8: Proxy writes made in serial-bus mode leave recovery control unchanged.
- R9: `activate_o` pulses for one cycle, in the cycle after a bypass-mode proxy write that takes a nonzero activation field to zero. In no other case does it pulse.
- R10: FIFO status (address 5) is read-only and packs these fields:
  - [0] empty flag;
  - [1] full flag;
  - [15:8] fill level;
  - [31:16] FIFO depth, which is 64 by default.
- R11: Reads of unmapped addresses (6 and above) return 0. Writes to the read-only addresses 0, 1 and 5 have no effect.
- R12: A read request gives `rd_valid` high, with the addressed word on `rd_data`, in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (4) | Word address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| dev_rec_ready | input | 1 | Device is in recovery mode and ready for an image |
| image_active | input | 1 | Consumer reports the activated image is running |
| fifo_level | input | LVL_W (7) | Indirect FIFO fill level |
| fifo_full | input | 1 | Indirect FIFO full |
| fifo_empty | input | 1 | Indirect FIFO empty |
| bypass_o | output | 1 | Mode select, 1 means bypass |
| payload_avail_o | output | 1 | One-cycle payload-available pulse |
| activate_o | output | 1 | One-cycle image-activation pulse |

## Verification
The results become visible at these points:
- Register writes are visible on the cycle after the request edge.
- `payload_avail_o` and `activate_o` are high only in that cycle.
- Read data appears one cycle after the read request.
- A recovery-status step caused by a pulse lands one edge later again.

The bench drives each request at a falling edge and checks pulses at the next falling edge. Before any status read that follows a pulse, it inserts one idle cycle, so every sample falls after each register on the path has updated. Random recovery-control values and clear masks are checked against a bench model of the clear rule and of the activation condition.

// File: rtl/rcv_csr_pkg.sv
package rcv_csr_pkg;

    localparam int DATA_W = 32;
    localparam int CTRL_W = 12;

    // word addresses
    localparam int unsigned A_DEV   = 0;
    localparam int unsigned A_RSTAT = 1;
    localparam int unsigned A_CTRL  = 2;
    localparam int unsigned A_CFG   = 3;
    localparam int unsigned A_PROXY = 4;
    localparam int unsigned A_FIFO  = 5;

    localparam logic [7:0]        DEV_HEALTHY = 8'h01;
    localparam logic [7:0]        DEV_READY   = 8'h03;
    localparam logic [CTRL_W-1:0] ACT_MASK    = 12'hF00;

    localparam int CFG_BYPASS_BIT  = 0;
    localparam int CFG_PAYLOAD_BIT = 1;

    typedef enum logic [3:0] {
        RS_IDLE  = 4'h0,
        RS_AWAIT = 4'h1,
        RS_BOOT  = 4'h2,
        RS_DONE  = 4'h3
    } rec_state_e;

    typedef struct packed {
        logic dev;
        logic rstat;
        logic ctrl;
        logic cfg;
        logic proxy;
        logic fifo;
    } reg_sel_t;

    function automatic logic [CTRL_W-1:0] w1c_apply(
        input logic [CTRL_W-1:0] cur,
        input logic [CTRL_W-1:0] ones
    );
        return cur & ~ones;
    endfunction

    function automatic logic [DATA_W-1:0] pack_fifo(
        input logic        empty,
        input logic        full,
        input logic [7:0]  level,
        input logic [15:0] depth
    );
        return {depth, level, 6'b0, full, empty};
    endfunction

endpackage

// File: rtl/rcv_addr_dec.sv
module rcv_addr_dec
    import rcv_csr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    always_comb begin
        sel = '0;
        case (addr)
            ADDR_W'(A_DEV):   sel.dev   = 1'b1;
            ADDR_W'(A_RSTAT): sel.rstat = 1'b1;
            ADDR_W'(A_CTRL):  sel.ctrl  = 1'b1;
            ADDR_W'(A_CFG):   sel.cfg   = 1'b1;
            ADDR_W'(A_PROXY): sel.proxy = 1'b1;
            ADDR_W'(A_FIFO):  sel.fifo  = 1'b1;
            default:          sel       = '0;
        endcase
    end
endmodule

// File: rtl/rcv_ctrl_regs.sv
module rcv_ctrl_regs
    import rcv_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_t          sel,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              bypass_q,
    output logic              payload_q,
    output logic              activate_q,
    output logic              act_now
);
    logic              proxy_hit;
    logic [CTRL_W-1:0] cleared;

    assign proxy_hit = wr_en && sel.proxy && bypass_q;
    assign cleared   = w1c_apply(ctrl_q, wdata);
    // activation: a proxy clear that empties a nonzero activation field
    assign act_now   = proxy_hit && ((ctrl_q & ACT_MASK) != '0)
                                 && ((cleared & ACT_MASK) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            bypass_q   <= 1'b0;
            payload_q  <= 1'b0;
            activate_q <= 1'b0;
        end else begin
            payload_q  <= 1'b0;
            activate_q <= act_now;
            if (wr_en && sel.cfg) begin
                bypass_q  <= wdata[CFG_BYPASS_BIT];
                payload_q <= wdata[CFG_PAYLOAD_BIT] & bypass_q;
            end
            if (wr_en && sel.ctrl) begin
                ctrl_q <= wdata;
            end else if (proxy_hit) begin
                ctrl_q <= cleared;
            end
        end
    end
endmodule

// File: rtl/rcv_status_track.sv
module rcv_status_track
    import rcv_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dev_ready,
    input  logic       payload,
    input  logic       act_now,
    input  logic       img_active,
    output rec_state_e state
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RS_IDLE;
            armed <= 1'b0;
        end else begin
            case (state)
                RS_IDLE:  if (dev_ready) state <= RS_AWAIT;
                RS_AWAIT: if (payload)   state <= RS_BOOT;
                RS_BOOT: begin
                    if (act_now) armed <= 1'b1;
                    if (armed && img_active) state <= RS_DONE;
                end
                default: state <= state;
            endcase
        end
    end
endmodule

// File: rtl/rcv_csr_ctrl.sv
module rcv_csr_ctrl
    import rcv_csr_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int FIFO_DEPTH = 64,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              dev_rec_ready,
    input  logic              image_active,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    output logic              bypass_o,
    output logic              payload_avail_o,
    output logic              activate_o
);
    localparam logic [15:0] DEPTH_F = 16'(FIFO_DEPTH);

    reg_sel_t          sel;
    logic              wr_en;
    logic              rd_en;
    logic [CTRL_W-1:0] ctrl_q;
    logic              act_now;
    rec_state_e        state;
    logic [DATA_W-1:0] rd_mux;

    assign wr_en = req_valid && req_write;
    assign rd_en = req_valid && !req_write;

    rcv_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    rcv_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .sel        (sel),
        .wdata      (req_wdata[CTRL_W-1:0]),
        .ctrl_q     (ctrl_q),
        .bypass_q   (bypass_o),
        .payload_q  (payload_avail_o),
        .activate_q (activate_o),
        .act_now    (act_now)
    );

    rcv_status_track u_stat (
        .clk        (clk),
        .rst        (rst),
        .dev_ready  (dev_rec_ready),
        .payload    (payload_avail_o),
        .act_now    (act_now),
        .img_active (image_active),
        .state      (state)
    );

    always_comb begin
        rd_mux = '0;
        if (sel.dev)   rd_mux = {24'b0, dev_rec_ready ? DEV_READY : DEV_HEALTHY};
        if (sel.rstat) rd_mux = {28'b0, state};
        if (sel.ctrl)  rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        if (sel.cfg)   rd_mux = {30'b0, payload_avail_o, bypass_o};
        if (sel.fifo)  rd_mux = pack_fifo(fifo_empty, fifo_full, 8'(fifo_level), DEPTH_F);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/rcv_csr_ctrl_chk.sv
module rcv_csr_ctrl_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              bypass_o,
    input logic              payload_avail_o,
    input logic              activate_o,
    input logic              image_active,
    input logic [3:0]        state,
    input logic [11:0]       ctrl_q
);
    logic proxy_wr;
    assign proxy_wr = req_valid && req_write && (req_addr == ADDR_W'(4));

    assert_payload_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        payload_avail_o |=> !payload_avail_o);

    assert_payload_bypass_only_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(payload_avail_o) |-> $past(bypass_o));

    assert_proxy_ignored_serial_R8: assert property (@(posedge clk) disable iff (rst)
        (proxy_wr && !bypass_o) |=> $stable(ctrl_q));

    assert_activate_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(activate_o) |-> ($past(proxy_wr) && $past(bypass_o)));

    assert_activate_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        activate_o |=> !activate_o);

    assert_status_forward_R4: assert property (@(posedge clk) disable iff (rst)
        (state != $past(state)) |-> (state == $past(state) + 4'd1));

    assert_done_needs_image_R4: assert property (@(posedge clk) disable iff (rst)
        (state == 4'h3 && $past(state) == 4'h2) |-> $past(image_active));

    assert_read_valid_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid);

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr > ADDR_W'(5)) |=> (rd_data == 32'h0));
endmodule

bind rcv_csr_ctrl rcv_csr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_write       (req_write),
    .req_addr        (req_addr),
    .rd_valid        (rd_valid),
    .rd_data         (rd_data),
    .bypass_o        (bypass_o),
    .payload_avail_o (payload_avail_o),
    .activate_o      (activate_o),
    .image_active    (image_active),
    .state           (state),
    .ctrl_q          (ctrl_q)
);

// File: tb/tb_rcv_csr_ctrl.sv
module tb_rcv_csr_ctrl;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 64;
    localparam int LVL_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic              dev_rec_ready = 1'b0;
    logic              image_active = 1'b0;
    logic [LVL_W-1:0]  fifo_level = '0;
    logic              fifo_full = 1'b0;
    logic              fifo_empty = 1'b1;
    logic              bypass_o;
    logic              payload_avail_o;
    logic              activate_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rcv_csr_ctrl #(.ADDR_W(ADDR_W), .FIFO_DEPTH(DEPTH)) dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // request driven after a falling edge; its effect is visible at the next falling edge
    task automatic wr(input int addr, input logic [31:0] data);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = ADDR_W'(addr); req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(addr);
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 rd_valid", 32'(rd_valid), 32'd1);
        data = rd_data;
    endtask

    function automatic logic [31:0] fifo_word(logic e, logic f, logic [LVL_W-1:0] l);
        return {16'(DEPTH), 8'(l), 6'b0, f, e};
    endfunction

    function automatic bit act_expected(logic [11:0] cur, logic [11:0] m);
        return (cur[11:8] != 4'h0) && ((cur[11:8] & ~m[11:8]) == 4'h0);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [11:0] model;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 bypass", 32'(bypass_o), 0);
        check("R1 payload", 32'(payload_avail_o), 0);
        check("R1 activate", 32'(activate_o), 0);
        check("R1 rd_valid", 32'(rd_valid), 0);
        rd(3, v); check("R1 cfg", v, 0);
        rd(2, v); check("R1 ctrl", v, 0);
        rd(1, v); check("R1 rstat", v, 0);
        rd(0, v); check("R3 dev not ready", v, 32'h01);

        // serial-bus mode
        wr(2, 32'h0000_0ABC); rd(2, v); check("R6 ctrl rw", v, 32'hABC);
        wr(2, 32'hFFFF_FFFF); rd(2, v); check("R6 ctrl upper zero", v, 32'hFFF);
        wr(4, 32'h0000_0FFF);
        check("R9 no activate serial", 32'(activate_o), 0);
        rd(2, v); check("R8 proxy ignored", v, 32'hFFF);
        wr(3, 32'h2);
        check("R5 payload ignored serial", 32'(payload_avail_o), 0);
        rd(3, v); check("R5 cfg serial", v, 0);
        wr(0, 32'hFF); rd(0, v); check("R11 dev ro", v, 32'h01);
        wr(1, 32'h3);  rd(1, v); check("R11 rstat ro", v, 0);
        wr(5, 32'hFFFF_FFFF); rd(5, v); check("R11 fifo ro", v, fifo_word(1'b1, 1'b0, '0));
        rd(4, v); check("R7 proxy reads zero", v, 0);

        // enter bypass
        wr(3, 32'h1);
        check("R2 bypass_o", 32'(bypass_o), 1);
        rd(3, v); check("R2 cfg readback", v, 32'h1);

        // random control values and clear masks
        for (int i = 0; i < 40; i++) begin
            logic [11:0] w, m;
            bit ea;
            w = 12'($urandom);
            if ((i % 5) == 0) w[11:8] = 4'hF;
            m = ((i % 4) == 0) ? 12'hF00 : 12'($urandom);
            wr(2, {20'($urandom), w});
            model = w;
            ea = act_expected(model, m);
            wr(4, {20'($urandom), m});
            check("R9 activate", 32'(activate_o), 32'(ea));
            model = model & ~m;
            rd(2, v); check("R7 proxy clear", v, 32'(model));
        end

        // FIFO status
        for (int i = 0; i < 10; i++) begin
            fifo_level = LVL_W'($urandom % (DEPTH + 1));
            fifo_full  = 1'($urandom);
            fifo_empty = 1'($urandom);
            rd(5, v); check("R10 fifo status", v, fifo_word(fifo_empty, fifo_full, fifo_level));
        end

        // unmapped
        for (int i = 0; i < 12; i++) begin
            int a;
            a = 6 + int'($urandom % 10);
            wr(a, $urandom);
            rd(a, v); check("R11 unmapped", v, 0);
        end

        // recovery sequence
        dev_rec_ready = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(0, v); check("R3 dev ready", v, 32'h03);
        rd(1, v); check("R4 awaiting", v, 32'h1);
        wr(3, 32'h3);
        check("R5 payload pulse", 32'(payload_avail_o), 1);
        @(negedge clk);
        check("R5 payload one cycle", 32'(payload_avail_o), 0);
        rd(3, v); check("R5 self clear", v, 32'h1);
        rd(1, v); check("R4 booting", v, 32'h2);
        image_active = 1'b1;
        repeat (3) @(negedge clk);
        rd(1, v); check("R4 waits activation", v, 32'h2);
        wr(2, 32'hF05);
        wr(4, 32'hF00);
        check("R9 activate flow", 32'(activate_o), 1);
        @(negedge clk);
        check("R9 activate one cycle", 32'(activate_o), 0);
        rd(1, v); check("R4 success", v, 32'h3);
        rd(2, v); check("R7 field cleared", v, 32'h005);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule